// File: doc/BRIEF.md
# Sized Bitwise Logic Unit with Condition Flags

This block applies one of four bitwise operations (AND, inclusive OR, exclusive OR, or inversion) to a destination operand and an already resolved source operand. The operation works on a selected size of byte, word or long. Only the low part of the destination that the size covers is rewritten. All bits above that part keep the value they had in the destination operand.

Alongside the new destination value, the unit produces four condition flags: negative, zero, overflow and carry. Negative and zero are taken from the sized result only. Overflow and carry are always cleared. An incoming extend flag passes to the output unchanged. Operand fetch, address decoding and immediate extraction take place outside the block.

All outputs are registered, so a result appears one clock after its inputs are presented. A synchronous active-high reset clears every output.

Top module: `szlog_unit`

## Requirements
- R1: `op_sel` selects the operation on the sized portion: 2'b00 AND, 2'b01 OR, 2'b10 exclusive OR, 2'b11 bitwise NOT of the destination.
- R2: With `size_sel` = 2'b00 (byte), only bits 7:0 of the result are computed and bits 31:8 equal `dst_in[31:8]`. For example, AND of byte $AA into $0000FFFF gives $0000FFAA.
- R3: With `size_sel` = 2'b01 (word), bits 15:0 are computed and bits 31:16 equal `dst_in[31:16]`.
- R4: With `size_sel` = 2'b10 (long), all 32 bits are computed. The unused code 2'b11 behaves exactly like long.
- R5: `n_out` equals the most significant bit of the sized result: bit 7 for byte, bit 15 for word, bit 31 for long.
- R6: `z_out` is 1 exactly when every bit of the sized result is 0, whatever the preserved upper bits hold. For example, NOT of byte $FF gives $00 with Z=1.
- R7: `v_out` and `c_out` are 0 after every operation.
- R8: `x_out` equals the `x_in` presented with the same operation, unmodified.
- R9: NOT ignores `src_in`: any source value gives the same result and flags.
- R10: Outputs change one clock after the inputs are sampled. A synchronous reset drives `res_out` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation code |
| size_sel | input | 2 | Operation size code |
| dst_in | input | 32 | Destination operand |
| src_in | input | 32 | Resolved source operand |
| x_in | input | 1 | Incoming extend flag |
| res_out | output | 32 | New destination value (registered) |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag, always 0 |
| c_out | output | 1 | Carry flag, always 0 |
| x_out | output | 1 | Extend flag, passed through |

## Verification
The bench builds the unit with its default 32-bit width and byte-wide lanes. With that build, all three operand sizes and the reserved size code can be reached, and the byte, word and long boundaries sit at bits 7, 15 and 31. Directed cases cover the documented byte examples, a zero low part under nonzero upper bits, and NOT with differing sources. Seeded random operands, operations and sizes then cover mixed lane patterns against a model computed in the bench.

// File: rtl/szlog_pkg.sv
package szlog_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_NOT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  localparam int LANE_W = 8;
endpackage

// File: rtl/szlog_bitop.sv
module szlog_bitop
  import szlog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] raw
);
  // one small mux per bit; maps to a single LUT level each
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign raw[b] = (op == OP_AND) ? (dst[b] & src[b]) :
                    (op == OP_OR)  ? (dst[b] | src[b]) :
                    (op == OP_XOR) ? (dst[b] ^ src[b]) :
                                     ~dst[b];
  end
endmodule

// File: rtl/szlog_merge.sv
module szlog_merge
  import szlog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  size_e             size,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] merged,
  output logic              sized_msb,
  output logic              sized_zero
);
  localparam int LANES      = DATA_W / LANE_W;
  localparam int WORD_LANES = (LANES < 2) ? LANES : 2;
  localparam int WORD_MSB   = WORD_LANES * LANE_W - 1;

  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_nz;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign lane_wr[i] = 1'b1;
    end else if (i < WORD_LANES) begin : g_word
      assign lane_wr[i] = (size != SZ_BYTE);
    end else begin : g_long
      assign lane_wr[i] = (size == SZ_LONG) || (size == SZ_RSVD);
    end
    assign merged[i*LANE_W +: LANE_W] = lane_wr[i] ? raw[i*LANE_W +: LANE_W]
                                                   : dst[i*LANE_W +: LANE_W];
    assign lane_nz[i] = lane_wr[i] & (|raw[i*LANE_W +: LANE_W]);
  end

  assign sized_zero = ~(|lane_nz);

  always_comb begin
    case (size)
      SZ_BYTE: sized_msb = raw[LANE_W-1];
      SZ_WORD: sized_msb = raw[WORD_MSB];
      default: sized_msb = raw[DATA_W-1];
    endcase
  end
endmodule

// File: rtl/szlog_unit.sv
module szlog_unit
  import szlog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic              x_in,
  output logic [DATA_W-1:0] res_out,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              c_out,
  output logic              x_out
);
  op_e               op;
  size_e             size;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] merged;
  logic              msb;
  logic              zero;

  assign op   = op_e'(op_sel);
  assign size = size_e'(size_sel);

  szlog_bitop #(.DATA_W(DATA_W)) u_bitop (
    .op  (op),
    .dst (dst_in),
    .src (src_in),
    .raw (raw)
  );

  szlog_merge #(.DATA_W(DATA_W)) u_merge (
    .size       (size),
    .raw        (raw),
    .dst        (dst_in),
    .merged     (merged),
    .sized_msb  (msb),
    .sized_zero (zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      n_out   <= 1'b0;
      z_out   <= 1'b0;
      v_out   <= 1'b0;
      c_out   <= 1'b0;
      x_out   <= 1'b0;
    end else begin
      res_out <= merged;
      n_out   <= msb;
      z_out   <= zero;
      v_out   <= 1'b0;
      c_out   <= 1'b0;
      x_out   <= x_in;
    end
  end

  // R2
  byte_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && size_sel == 2'b00) |=> res_out[DATA_W-1:8] == $past(dst_in[DATA_W-1:8]));

  // R3
  word_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && size_sel == 2'b01) |=> res_out[DATA_W-1:16] == $past(dst_in[DATA_W-1:16]));

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> n_out == (($past(size_sel) == 2'b00) ? res_out[7] :
                       ($past(size_sel) == 2'b01) ? res_out[15] : res_out[DATA_W-1]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> z_out == (($past(size_sel) == 2'b00) ? (res_out[7:0] == '0) :
                       ($past(size_sel) == 2'b01) ? (res_out[15:0] == '0) : (res_out == '0)));

  // R7
  vc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (!v_out && !c_out));

  // R8
  x_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> x_out == $past(x_in));

  // R9
  not_ignores_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_sel == 2'b11 && size_sel == 2'b10) |=> res_out == ~$past(dst_in));
endmodule

// File: tb/test_szlog_unit.sv
`timescale 1ns/1ps
module test_szlog_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic [31:0] dst_in = '0;
  logic [31:0] src_in = '0;
  logic        x_in = 1'b0;
  logic [31:0] res_out;
  logic        n_out, z_out, v_out, c_out, x_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  szlog_unit i_szlog_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .size_sel(size_sel),
    .dst_in(dst_in), .src_in(src_in), .x_in(x_in),
    .res_out(res_out), .n_out(n_out), .z_out(z_out),
    .v_out(v_out), .c_out(c_out), .x_out(x_out)
  );

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] model_res(input logic [1:0] op, input logic [1:0] sz,
                                            input logic [31:0] d, input logic [31:0] s);
    logic [31:0] r;
    case (op)
      2'b00:   r = d & s;
      2'b01:   r = d | s;
      2'b10:   r = d ^ s;
      default: r = ~d;
    endcase
    return (r & size_mask(sz)) | (d & ~size_mask(sz));
  endfunction

  function automatic logic model_n(input logic [1:0] sz, input logic [31:0] r);
    case (sz)
      2'b00:   return r[7];
      2'b01:   return r[15];
      default: return r[31];
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] d,
                        input logic [31:0] s, input logic x);
    logic [31:0] er;
    string rtag;
    @(negedge clk);
    op_sel = op; size_sel = sz; dst_in = d; src_in = s; x_in = x;
    er = model_res(op, sz, d, s);
    rtag = (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R4";
    @(negedge clk);
    check(rtag, res_out, er);
    check("R5", {31'b0, n_out}, {31'b0, model_n(sz, er)});
    check("R6", {31'b0, z_out}, {31'b0, ((er & size_mask(sz)) == 0)});
    check("R7", {30'b0, v_out, c_out}, 32'b0);
    check("R8", {31'b0, x_out}, {31'b0, x});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {res_out[31:0]}, 32'b0);
    check("R10", {27'b0, n_out, z_out, v_out, c_out, x_out}, 32'b0);
    rst = 1'b0;

    // R1 R2 documented byte cases
    run_op(2'b00, 2'b00, 32'h0000_FFFF, 32'h0000_00AA, 1'b1);
    check("R1", {31'b0, n_out}, 32'd1);
    run_op(2'b10, 2'b00, 32'h0000_FFBB, 32'h0000_0067, 1'b0);
    check("R1", res_out, 32'h0000_FFDC);
    run_op(2'b11, 2'b00, 32'h0000_FFFF, 32'h1234_5678, 1'b1);
    check("R6", {31'b0, z_out}, 32'd1);
    check("R2", res_out, 32'h0000_FF00);
    // R6 zero low part under nonzero upper bits, word size
    run_op(2'b00, 2'b01, 32'hFFFF_00FF, 32'hFFFF_FF00, 1'b0);
    check("R3", res_out, 32'hFFFF_0000);
    // R4 reserved code acts as long
    run_op(2'b01, 2'b11, 32'h8000_0000, 32'h0000_0001, 1'b0);
    check("R4", res_out, 32'h8000_0001);
    // R9 NOT with two different sources
    run_op(2'b11, 2'b10, 32'h0F0F_1234, 32'h0000_0000, 1'b0);
    keep = res_out;
    run_op(2'b11, 2'b10, 32'h0F0F_1234, 32'hFFFF_FFFF, 1'b1);
    check("R9", res_out, keep);

    // R10 latency: output holds until the next edge
    @(negedge clk);
    keep = res_out;
    op_sel = 2'b01; size_sel = 2'b10; dst_in = ~keep; src_in = 32'h0; x_in = 1'b0;
    #1;
    check("R10", res_out, keep);
    @(negedge clk);
    check("R10", res_out, ~keep);

    // random mix
    for (int k = 0; k < 1500; k++) begin
      run_op(2'($urandom), 2'($urandom), $urandom, $urandom, 1'($urandom));
    end

    // R10 synchronous reset clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10", res_out, 32'b0);
    check("R10", {27'b0, n_out, z_out, v_out, c_out, x_out}, 32'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule